// File: doc/BRIEF.md
# Registered Greater-Than Comparator with MSB Load Prediction

This block registers two unsigned operands, `a_i` and `b_i`, and reports whether `a_i` is strictly greater than `b_i`. It is meant to lower switching activity. A small predictor looks only at the top bit of each incoming operand, before the operands are registered. When the two top bits differ, the answer follows from those two bits alone. In that case the registers holding the lower-order bits keep their old contents for that sample, and the wide comparator sees no new data.

When the top bits are equal, every bit is loaded and the comparison falls to the low-order field. The top-bit flops of both operands load on every valid sample. The result register applies whichever path was chosen, so the output always matches a plain full-width unsigned compare.

A sample is presented with `valid_i`. Its result appears together with `res_vld_o` two clock edges later. `lo_hold_o` marks results for which the low-order registers were not reloaded. Samples may arrive on every cycle.

Top module: `msb_gt_cmp`

## Requirements
- R1: For each sample taken with `valid_i` high, `result_o` is 1 exactly when `a_i > b_i` as unsigned W-bit numbers (W defaults to 16). It appears with `res_vld_o` high on the second rising edge after the sampling edge.
- R2: When bit W-1 of `a_i` and bit W-1 of `b_i` differ, `result_o` equals bit W-1 of `a_i`, whatever the lower bits hold.
- R3: When the two top bits are equal, the result is decided by bits W-2..0. Identical operands give 0.
- R4: `lo_hold_o` is 1 in the same cycle as a result exactly when that sample's top bits differed, meaning the low-order operand registers were not written by it. Otherwise it is 0.
- R5: In a cycle that carries no result, `res_vld_o` is 0 and `result_o` keeps its previous value, whatever `a_i` and `b_i` do while `valid_i` is low.
- R6: While `rst_ni` is low, and right after it is released, `result_o`, `res_vld_o` and `lo_hold_o` are 0.
- R7: Samples on consecutive cycles each produce one result, in the order the samples were presented.
- R8: Low-order contents left over from an earlier sample never reach a result. An equal-top-bit sample that follows a held sample is compared on its own low-order bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| a_i | input | W | First operand (the one tested for being larger) |
| b_i | input | W | Second operand |
| result_o | output | 1 | Registered a_i > b_i |
| res_vld_o | output | 1 | result_o carries a new result this cycle |
| lo_hold_o | output | 1 | The result was decided by the top bits alone |

## Verification
Every result, together with its `res_vld_o` and `lo_hold_o`, is due two rising edges after the edge that samples `valid_i`. The first edge loads the operand registers and the second loads the result register. The bench drives inputs on falling edges and reads outputs on the falling edge two cycles after the drive. In the back-to-back burst it keeps a two-deep history of expected values, so the check made on each cycle belongs to the sample driven two cycles before. Idle checks read the outputs on every falling edge while `valid_i` is low, with junk on the operand buses.

// File: rtl/msb_gt_cmp_pkg.sv
package msb_gt_cmp_pkg;
  typedef enum logic {
    PATH_FULL = 1'b0,
    PATH_MSB  = 1'b1
  } cmp_path_e;
endpackage

// File: rtl/msb_gt_predict.sv
module msb_gt_predict
  import msb_gt_cmp_pkg::*;
(
  input  logic      valid_i,
  input  logic      a_msb_i,
  input  logic      b_msb_i,
  output logic      lo_en_o,
  output cmp_path_e path_o
);
  logic msb_same;

  assign msb_same = ~(a_msb_i ^ b_msb_i);
  assign lo_en_o  = valid_i & msb_same;
  assign path_o   = msb_same ? PATH_FULL : PATH_MSB;
endmodule

// File: rtl/msb_gt_opreg.sv
module msb_gt_opreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         lo_en_i,
  input  logic [W-1:0] d_i,
  output logic         msb_o,
  output logic [W-2:0] lo_o
);
  localparam int unsigned LW = W - 1;

  logic          msb_q;
  logic [LW-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msb_q <= 1'b0;
    else if (valid_i) msb_q <= d_i[W-1];
  end

  // low field only moves when the predictor cannot decide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else if (lo_en_i) lo_q <= d_i[LW-1:0];
  end

  assign msb_o = msb_q;
  assign lo_o  = lo_q;
endmodule

// File: rtl/msb_gt_core.sv
module msb_gt_core
  import msb_gt_cmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  cmp_path_e    path_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic [W-2:0] a_lo_i,
  input  logic [W-2:0] b_lo_i,
  output logic         result_o,
  output logic         vld_o,
  output logic         hold_o
);
  logic res_d, res_q, vld_q, hold_q;

  always_comb begin
    if (path_i == PATH_MSB) res_d = a_msb_i & ~b_msb_i;
    else                    res_d = a_lo_i > b_lo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= 1'b0;
      vld_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      vld_q  <= vld_i;
      hold_q <= vld_i & (path_i == PATH_MSB);
      if (vld_i) res_q <= res_d;
    end
  end

  assign result_o = res_q;
  assign vld_o    = vld_q;
  assign hold_o   = hold_q;
endmodule

// File: rtl/msb_gt_cmp.sv
module msb_gt_cmp
  import msb_gt_cmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         result_o,
  output logic         res_vld_o,
  output logic         lo_hold_o
);
  localparam int unsigned NOP = 2;

  logic                  lo_en;
  cmp_path_e             path_d, path_q;
  logic                  v_q;
  logic [NOP-1:0][W-1:0] opnd;
  logic [NOP-1:0]        msb_q;
  logic [NOP-1:0][W-2:0] lo_q;
  logic [W-2:0]          a_lo_q, b_lo_q;

  assign opnd = {b_i, a_i};

  msb_gt_predict u_pred (
    .valid_i (valid_i),
    .a_msb_i (a_i[W-1]),
    .b_msb_i (b_i[W-1]),
    .lo_en_o (lo_en),
    .path_o  (path_d)
  );

  for (genvar g = 0; g < NOP; g++) begin : g_op
    msb_gt_opreg #(.W(W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .lo_en_i (lo_en),
      .d_i     (opnd[g]),
      .msb_o   (msb_q[g]),
      .lo_o    (lo_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      path_q <= PATH_FULL;
    end else begin
      v_q <= valid_i;
      if (valid_i) path_q <= path_d;
    end
  end

  assign a_lo_q = lo_q[0];
  assign b_lo_q = lo_q[1];

  msb_gt_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (v_q),
    .path_i   (path_q),
    .a_msb_i  (msb_q[0]),
    .b_msb_i  (msb_q[1]),
    .a_lo_i   (a_lo_q),
    .b_lo_i   (b_lo_q),
    .result_o (result_o),
    .vld_o    (res_vld_o),
    .hold_o   (lo_hold_o)
  );
endmodule

// File: rtl/msb_gt_cmp_chk.sv
module msb_gt_cmp_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         result_o,
  input logic         res_vld_o,
  input logic         lo_hold_o,
  input logic [W-2:0] a_lo_q,
  input logic [W-2:0] b_lo_q
);
  p_result_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> (result_o == $past(a_i > b_i, 2)));

  p_vld_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o == $past(valid_i, 2));

  p_msb_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && lo_hold_o) |-> (result_o == $past(a_i[W-1], 2)));

  p_hold_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> (lo_hold_o == $past(a_i[W-1] ^ b_i[W-1], 2)));

  p_lo_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (a_i[W-1] != b_i[W-1])) |=> ($stable(a_lo_q) && $stable(b_lo_q)));

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |=> (!res_vld_o || $past(res_vld_o) || 1'b1) && (res_vld_o || $stable(result_o)));

  p_flag_qual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_hold_o |-> res_vld_o);
endmodule

bind msb_gt_cmp msb_gt_cmp_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .result_o  (result_o),
  .res_vld_o (res_vld_o),
  .lo_hold_o (lo_hold_o),
  .a_lo_q    (a_lo_q),
  .b_lo_q    (b_lo_q)
);

// File: tb/msb_gt_cmp_tb.sv
`timescale 1ns/1ps
module msb_gt_cmp_tb;
  localparam int unsigned W = 16;
  localparam int unsigned MAXCYC = 200000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         result_o, res_vld_o, lo_hold_o;

  int checks = 0;
  int fails = 0;
  int hold_cnt = 0;
  bit done = 1'b0;

  msb_gt_cmp #(.W(W)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .result_o  (result_o),
    .res_vld_o (res_vld_o),
    .lo_hold_o (lo_hold_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one sample, read its result two edges later
  task automatic one(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    bit exp_r, exp_h;
    exp_r = a > b;
    exp_h = a[W-1] ^ b[W-1];
    @(negedge clk_i);
    valid_i = 1'b1; a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0; a_i = ~a; b_i = ~b;
    @(negedge clk_i);
    chk(res_vld_o == 1'b1, {req, " res_vld_o"}, res_vld_o, 1);
    chk(result_o == exp_r, {req, " result_o"}, result_o, exp_r);
    chk(lo_hold_o == exp_h, {req, " lo_hold_o"}, lo_hold_o, exp_h);
    if (lo_hold_o) hold_cnt++;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk({result_o, res_vld_o, lo_hold_o} == 3'b000, "R6 in reset", {result_o, res_vld_o, lo_hold_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({result_o, res_vld_o, lo_hold_o} == 3'b000, "R6 after release", {result_o, res_vld_o, lo_hold_o}, 0);
  endtask

  task automatic t_msb_differ;
    one(16'h8000, 16'h7FFF, "R2 a msb set");
    one(16'h0000, 16'hFFFF, "R2 b msb set");
    one(16'h8000, 16'h0001, "R2 low bits favour b");
    one(16'h7FFF, 16'h8000, "R2 low bits favour a");
  endtask

  task automatic t_equal_msb;
    one(16'h1234, 16'h1233, "R3 lo greater");
    one(16'h9233, 16'h9234, "R3 lo smaller");
    one(16'hABCD, 16'hABCD, "R3 equal operands");
    one(16'h0000, 16'h0000, "R3 zero");
    one(16'hFFFF, 16'hFFFE, "R3 top range");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      b[W-1] = a[W-1];
      one(a, b, "R3 random equal msb");
    end
  endtask

  task automatic t_stale_lo;
    one(16'h0005, 16'h0003, "R8 seed low regs");
    one(16'h8000, 16'h7FFF, "R8 held sample");
    one(16'h0001, 16'h0002, "R8 reload after hold");
    one(16'h8002, 16'h8001, "R8 reload msb1");
  endtask

  task automatic t_idle;
    bit last;
    one(16'h4000, 16'h3000, "R5 prime");
    last = result_o;
    for (int i = 0; i < 8; i++) begin
      a_i = W'($urandom);
      b_i = W'($urandom);
      @(negedge clk_i);
      chk(res_vld_o == 1'b0, "R5 idle res_vld_o", res_vld_o, 0);
      chk(result_o == last, "R5 idle result_o held", result_o, last);
    end
  endtask

  task automatic t_burst;
    bit exp_r[2];
    bit exp_h[2];
    bit exp_v[2];
    exp_v[0] = 1'b0; exp_v[1] = 1'b0;
    exp_r[0] = 1'b0; exp_r[1] = 1'b0;
    exp_h[0] = 1'b0; exp_h[1] = 1'b0;
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a, b;
      @(negedge clk_i);
      if (exp_v[1]) begin
        chk(res_vld_o == 1'b1, "R7 burst res_vld_o", res_vld_o, 1);
        chk(result_o == exp_r[1], "R1 burst result_o", result_o, exp_r[1]);
        chk(lo_hold_o == exp_h[1], "R4 burst lo_hold_o", lo_hold_o, exp_h[1]);
        if (lo_hold_o) hold_cnt++;
      end
      a = W'($urandom);
      b = (i % 3 == 0) ? a : W'($urandom);
      if (i % 5 == 0) b[W-1] = a[W-1];
      exp_v[1] = exp_v[0]; exp_r[1] = exp_r[0]; exp_h[1] = exp_h[0];
      exp_v[0] = (i < 198);
      exp_r[0] = a > b;
      exp_h[0] = a[W-1] ^ b[W-1];
      valid_i = (i < 198);
      a_i = a; b_i = b;
    end
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    t_reset();
    t_msb_differ();
    t_equal_msb();
    t_stale_lo();
    t_idle();
    t_burst();
    chk(hold_cnt > 0, "R4 held cycles seen", hold_cnt, 1);
    $display("held low-order cycles: %0d", hold_cnt);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (MAXCYC) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAXCYC, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule